// File: doc/BRIEF.md
# Fixed-Point Fractional System Time Counter

This block keeps a 64-bit system time as a fixed-point number. On every cycle in which the oscillator tick input is high, it adds a programmable increment to the time. The upper part of the result counts nanoseconds and the lower part holds a binary fraction of a nanosecond. The position of the binary point depends on the link speed. A nanosecond view is produced by a plain right shift of the raw time. Software trims the clock frequency by rewriting the wide fractional increment at run time. It sets the time by writing two 32-bit words and reads it back as two 32-bit words.

Two small state machines control register access. The write stager has the states WS_EMPTY and WS_LOW_HELD. A low-word write moves it from WS_EMPTY to WS_LOW_HELD, or stays in WS_LOW_HELD and replaces the staged word. A high-word write commits both words in one cycle and returns the stager to WS_EMPTY. The read sequencer has the states RS_LIVE and RS_SHADOW. A low-word read moves it to RS_SHADOW and captures the high word into a shadow register. A high-word read returns the shadow when in RS_SHADOW, or the live high word when in RS_LIVE, and then moves to RS_LIVE. Other reads leave it where it is.

The parameter NARROW selects between two configurations. With NARROW=0 the increment is 31 bits wide. With NARROW=1 the increment is 24 bits wide, and an 8-bit period field sits above it.

Top module: `fxp_time_counter`

## Requirements
- R1: After reset the time is zero, the wrap pulse is low, and the increment register holds the fastest-speed default. This default is 0x66666666 with NARROW=0 and 0x01CCCCCC with NARROW=1 (period 1, value 0x66666666 shifted right by 7).
- R2: Each cycle that an addition is enabled, the time grows by the increment value, and carries propagate from the low word into the high word. Cycles without an addition leave the time unchanged.
- R3: Select codes are 0 for the time low word, 1 for the time high word, 2 for the increment, and 3 for nothing. A low-word write only stages the word. A high-word write loads {high, staged low} in one cycle and clears the staged word to zero. A time write wins over a tick in the same cycle, and that tick is lost.
- R4: A low-word read returns the live low word and captures the live high word into a shadow register. A high-word read that comes after a low-word read returns the shadow, even when ticks occur in between. A high-word read that is not preceded by a low-word read returns the live high word.
- R5: A written increment applies to ticks in the cycles after the write. A tick in the write cycle still uses the old value. Reading select 2 returns the stored increment.
- R6: With NARROW=0, bit 31 of an increment write is dropped. It reads back as 0 and adds nothing.
- R7: With NARROW=1, bits 31:24 of the increment register are a period P and bits 23:0 are the value. An addition happens on every P-th tick, and P=0 behaves as P=1. Every increment write restarts the tick count from zero.
- R8: When an addition carries out of bit 63, the wrap output is high for exactly the one cycle after it. A time write never raises the wrap output.
- R9: The nanosecond output equals the time shifted right by F bits. The speed input selects F: speed 0 or 3 gives 28, speed 1 gives 24, and speed 2 gives 21, each 7 less when NARROW=1.
- R10: Read data and the read-valid flag appear one cycle after the read request. Select 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator tick enable |
| spd | input | 2 | Link speed code selecting the binary point |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select (0 time low, 1 time high, 2 increment) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read select, same codes as for writes |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| wrap_pulse | output | 1 | One-cycle pulse on carry out of bit 63 |
| time_ns | output | 64 | Time converted to nanoseconds by a right shift |

## Verification
The bench targets the atomic split read. It lets ticks run between the low-word read and the high-word read, so a design that returned the live high word would show the carried value instead of the shadow. It ticks in the same cycle as a time write and as an increment write; a design with the wrong priority or the wrong timing would show an extra or a wrong addition. It forces a carry out of bit 63 to check that the wrap pulse lasts exactly one cycle. In the narrow configuration it tests period 0 and the restart of the tick count on an increment write; a divider that did not restart would add one tick too early.

// File: rtl/fxtc_pkg.sv
package fxtc_pkg;

    localparam int WORD_W       = 32;
    localparam int TIME_W       = 2 * WORD_W;
    localparam int NARROW_SHIFT = 7;
    localparam int PERIOD_W     = 8;
    localparam logic [WORD_W-1:0] BASE_INC_FAST = 32'h6666_6666;

    typedef enum logic [1:0] {
        SEL_TLO  = 2'd0,
        SEL_THI  = 2'd1,
        SEL_INC  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        WS_EMPTY,
        WS_LOW_HELD
    } wr_state_e;

    typedef enum logic {
        RS_LIVE,
        RS_SHADOW
    } rd_state_e;

    // Binary-point position for a speed code; the narrow build loses 7 bits.
    function automatic int unsigned frac_bits(input logic [1:0] speed, input bit narrow);
        int unsigned b;
        case (speed)
            2'd1:    b = 24;
            2'd2:    b = 21;
            default: b = 28;
        endcase
        return narrow ? (b - NARROW_SHIFT) : b;
    endfunction

endpackage

// File: rtl/fxtc_tick_gate.sv
module fxtc_tick_gate #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                restart,
    input  logic [PERIOD_W-1:0] period,
    output logic                add_en
);
    logic [PERIOD_W-1:0] cnt_q, cnt_d, limit;

    always_comb begin
        limit = (period == '0) ? '0 : period - 1'b1;
    end

    always_comb begin
        add_en = tick && (cnt_q >= limit);
        cnt_d  = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (tick)
            cnt_d = (cnt_q >= limit) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: an addition only ever happens on a tick
    assert_add_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |-> tick);

    // R7: a restart always returns the count to zero
    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/fxtc_accum.sv
module fxtc_accum #(
    parameter int TIME_W = 64,
    parameter int INC_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic [INC_W-1:0]  inc_val,
    input  logic              commit,
    input  logic [TIME_W-1:0] commit_val,
    output logic [TIME_W-1:0] time_q,
    output logic              wrap_pulse
);
    logic [TIME_W:0] sum;

    always_comb begin
        sum = {1'b0, time_q} + {{(TIME_W+1-INC_W){1'b0}}, inc_val};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q     <= '0;
            wrap_pulse <= 1'b0;
        end else if (commit) begin
            time_q     <= commit_val;
            wrap_pulse <= 1'b0;
        end else if (add_en) begin
            time_q     <= sum[TIME_W-1:0];
            wrap_pulse <= sum[TIME_W];
        end else begin
            wrap_pulse <= 1'b0;
        end
    end

    // R3: a committed write lands exactly
    assert_commit_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (time_q == $past(commit_val)));

    // R2: without add or commit the time holds
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !add_en) |=> $stable(time_q));

    // R8: the wrap pulse never lasts two cycles
    assert_wrap_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse);

    // R8: a write never signals a wrap
    assert_no_wrap_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !wrap_pulse);

endmodule

// File: rtl/fxtc_regif.sv
module fxtc_regif
    import fxtc_pkg::*;
#(
    parameter bit NARROW = 1'b0,
    parameter int INC_REG_W = NARROW ? WORD_W : WORD_W - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [1:0]           rd_sel,
    input  logic [TIME_W-1:0]    time_q,
    output logic                 commit,
    output logic [TIME_W-1:0]    commit_val,
    output logic [INC_REG_W-1:0] inc_q,
    output logic                 inc_wr,
    output logic                 rd_valid,
    output logic [WORD_W-1:0]    rd_data
);
    localparam logic [WORD_W-1:0] NARROW_RST =
        (WORD_W'(1) << (WORD_W - PERIOD_W)) | (BASE_INC_FAST >> NARROW_SHIFT);
    localparam logic [WORD_W-1:0] RST_FULL = NARROW ? NARROW_RST : BASE_INC_FAST;
    localparam logic [INC_REG_W-1:0] INC_RST = RST_FULL[INC_REG_W-1:0];

    reg_sel_e wsel, rsel;
    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    // ---------------- write stager ----------------
    wr_state_e           ws_q, ws_d;
    logic [WORD_W-1:0]   stage_q, stage_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q    <= WS_EMPTY;
            stage_q <= '0;
        end else begin
            ws_q    <= ws_d;
            stage_q <= stage_d;
        end
    end

    always_comb begin
        ws_d       = ws_q;
        stage_d    = stage_q;
        commit     = 1'b0;
        commit_val = {wr_data, stage_q};
        if (wr_en) begin
            unique case (wsel)
                SEL_TLO: begin
                    stage_d = wr_data;
                    ws_d    = WS_LOW_HELD;
                end
                SEL_THI: begin
                    commit  = 1'b1;
                    stage_d = '0;
                    ws_d    = WS_EMPTY;
                end
                SEL_INC, SEL_NONE: ;
            endcase
        end
    end

    // ---------------- increment register ----------------
    assign inc_wr = wr_en && (wsel == SEL_INC);

    always_ff @(posedge clk) begin
        if (!rst_n)      inc_q <= INC_RST;
        else if (inc_wr) inc_q <= wr_data[INC_REG_W-1:0];
    end

    // ---------------- read sequencer ----------------
    rd_state_e         rs_q, rs_d;
    logic [WORD_W-1:0] shadow_q, rd_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q     <= RS_LIVE;
            shadow_q <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rs_q     <= rs_d;
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_next;
            if (rd_en && (rsel == SEL_TLO)) shadow_q <= time_q[TIME_W-1:WORD_W];
        end
    end

    always_comb begin
        rs_d    = rs_q;
        rd_next = '0;
        unique case (rsel)
            SEL_TLO: begin
                rd_next = time_q[WORD_W-1:0];
                if (rd_en) rs_d = RS_SHADOW;
            end
            SEL_THI: begin
                rd_next = (rs_q == RS_SHADOW) ? shadow_q : time_q[TIME_W-1:WORD_W];
                if (rd_en) rs_d = RS_LIVE;
            end
            SEL_INC:  rd_next = WORD_W'(inc_q);
            SEL_NONE: rd_next = '0;
        endcase
    end

    // R4: a high read in the shadow state returns the captured word
    assert_shadow_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rsel == SEL_THI && rs_q == RS_SHADOW) |=> (rd_data == $past(shadow_q)));

    // R10: every request yields valid data in the next cycle
    assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R3: a high write always empties the stager
    assert_stage_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (ws_q == WS_EMPTY && stage_q == '0));

endmodule

// File: rtl/fxp_time_counter.sv
module fxp_time_counter
    import fxtc_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic [1:0]        spd,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              wrap_pulse,
    output logic [TIME_W-1:0] time_ns
);
    localparam int INC_REG_W = NARROW ? WORD_W : WORD_W - 1;
    localparam int INC_W     = NARROW ? WORD_W - PERIOD_W : WORD_W - 1;

    logic                 commit, inc_wr, add_en;
    logic [TIME_W-1:0]    commit_val, time_q;
    logic [INC_REG_W-1:0] inc_q;
    logic [INC_W-1:0]     inc_val;

    fxtc_regif #(.NARROW(NARROW), .INC_REG_W(INC_REG_W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_sel     (rd_sel),
        .time_q     (time_q),
        .commit     (commit),
        .commit_val (commit_val),
        .inc_q      (inc_q),
        .inc_wr     (inc_wr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    generate
        if (NARROW) begin : g_narrow
            assign inc_val = inc_q[INC_W-1:0];
            fxtc_tick_gate #(.PERIOD_W(PERIOD_W)) u_gate (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (osc_tick),
                .restart (inc_wr),
                .period  (inc_q[INC_REG_W-1:INC_W]),
                .add_en  (add_en)
            );
        end else begin : g_wide
            assign inc_val = inc_q;
            assign add_en  = osc_tick;
        end
    endgenerate

    fxtc_accum #(.TIME_W(TIME_W), .INC_W(INC_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .add_en     (add_en),
        .inc_val    (inc_val),
        .commit     (commit),
        .commit_val (commit_val),
        .time_q     (time_q),
        .wrap_pulse (wrap_pulse)
    );

    always_comb begin
        time_ns = time_q >> frac_bits(spd, NARROW);
    end

    // R2: an enabled addition advances time by exactly the increment (mod 2^64)
    assert_tick_adds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !commit) |=> (time_q == $past(time_q) + TIME_W'($past(inc_val))));

endmodule

// File: tb/fxp_time_counter_tb.sv
module fxp_time_counter_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [1:0]       osc_tick = '0, wr_en = '0, rd_en = '0, rd_valid, wrap;
    logic [1:0][1:0]  spd = '0, wr_sel = '0, rd_sel = '0;
    logic [1:0][31:0] wr_data = '0, rd_data;
    logic [1:0][63:0] tns;

    fxp_time_counter #(.NARROW(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick[0]), .spd(spd[0]),
        .wr_en(wr_en[0]), .wr_sel(wr_sel[0]), .wr_data(wr_data[0]),
        .rd_en(rd_en[0]), .rd_sel(rd_sel[0]), .rd_valid(rd_valid[0]),
        .rd_data(rd_data[0]), .wrap_pulse(wrap[0]), .time_ns(tns[0]));

    fxp_time_counter #(.NARROW(1'b1)) u_dut_n (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick[1]), .spd(spd[1]),
        .wr_en(wr_en[1]), .wr_sel(wr_sel[1]), .wr_data(wr_data[1]),
        .rd_en(rd_en[1]), .rd_sel(rd_sel[1]), .rd_valid(rd_valid[1]),
        .rd_data(rd_data[1]), .wrap_pulse(wrap[1]), .time_ns(tns[1]));

    typedef struct {
        int          tgt;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int checks = 0;
    int fails  = 0;
    int tgt    = 0;

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic tk);
        wr_en[tgt] = 1'b1; wr_sel[tgt] = sel; wr_data[tgt] = d; osc_tick[tgt] = tk;
        @(negedge clk);
        wr_en[tgt] = 1'b0; osc_tick[tgt] = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        exp_item_t it;
        it.tgt = tgt; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        rd_en[tgt] = 1'b1; rd_sel[tgt] = sel;
        @(negedge clk);
        rd_en[tgt] = 1'b0;
    endtask

    task automatic ticks(input int n);
        osc_tick[tgt] = 1'b1;
        repeat (n) @(negedge clk);
        osc_tick[tgt] = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        for (int t = 0; t < 2; t++) begin
            if (rst_n && rd_valid[t]) begin
                if (sb_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R10: unexpected read data %h on dut %0d", rd_data[t], t);
                end else begin
                    exp_item_t it;
                    it = sb_q.pop_front();
                    check({32'h0, rd_data[t]}, {32'h0, it.exp}, it.tag);
                    if (it.tgt != t) check(64'(t), 64'(it.tgt), "R10 target");
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        tgt = 0;
        check({63'h0, wrap[0]}, 64'h0, "R1 wrap");
        check(tns[0], 64'h0, "R1 ns");
        rd(2'd2, 32'h6666_6666, "R1 inc default");
        rd(2'd0, 32'h0, "R1 time low");
        rd(2'd1, 32'h0, "R1 time high");

        // R2 three ticks carry into high word
        ticks(3);
        rd(2'd0, 32'h3333_3332, "R2 low after 3 ticks");
        rd(2'd1, 32'h0000_0001, "R2 high after 3 ticks");

        // R3 staged write, R4 shadow read
        wr(2'd2, 32'h10, 1'b0);
        wr(2'd0, 32'hFFFF_FFF8, 1'b0);
        wr(2'd1, 32'h5, 1'b0);
        rd(2'd0, 32'hFFFF_FFF8, "R3 low after write");
        ticks(1);
        rd(2'd1, 32'h5, "R4 shadow high");
        rd(2'd1, 32'h6, "R4 live high");
        rd(2'd0, 32'h8, "R2 low after carry");

        // R3 write wins over a tick; high-only write clears low
        wr(2'd0, 32'h100, 1'b0);
        wr(2'd1, 32'h0, 1'b1);
        rd(2'd0, 32'h100, "R3 write over tick");
        wr(2'd1, 32'h7, 1'b0);
        rd(2'd0, 32'h0, "R3 high-only low");
        rd(2'd1, 32'h7, "R3 high-only high");

        // R5 increment change timing
        wr(2'd2, 32'h200, 1'b1);
        ticks(2);
        rd(2'd0, 32'h410, "R5 new increment");
        rd(2'd2, 32'h200, "R5 inc readback");

        // R6 bit 31 dropped
        wr(2'd2, 32'h8000_0003, 1'b0);
        rd(2'd2, 32'h3, "R6 bit31 reads zero");
        wr(2'd0, 32'h0, 1'b0);
        wr(2'd1, 32'h0, 1'b0);
        ticks(1);
        rd(2'd0, 32'h3, "R6 bit31 no effect");

        // R8 wrap pulse
        wr(2'd2, 32'h10, 1'b0);
        wr(2'd0, 32'hFFFF_FFF8, 1'b0);
        wr(2'd1, 32'hFFFF_FFFF, 1'b0);
        check({63'h0, wrap[0]}, 64'h0, "R8 no wrap on write");
        ticks(1);
        check({63'h0, wrap[0]}, 64'h1, "R8 wrap raised");
        rd(2'd0, 32'h8, "R8 low after wrap");
        check({63'h0, wrap[0]}, 64'h0, "R8 wrap one cycle");
        rd(2'd1, 32'h0, "R8 high after wrap");

        // R9 nanosecond view
        wr(2'd0, 32'h0, 1'b0);
        wr(2'd1, 32'h1, 1'b0);
        spd[0] = 2'd0; #1 check(tns[0], 64'h10,  "R9 speed 0");
        spd[0] = 2'd1; #1 check(tns[0], 64'h100, "R9 speed 1");
        spd[0] = 2'd2; #1 check(tns[0], 64'h800, "R9 speed 2");
        spd[0] = 2'd3; #1 check(tns[0], 64'h10,  "R9 speed 3");
        @(negedge clk);

        // R10 empty select
        rd(2'd3, 32'h0, "R10 select 3");

        // R7 narrow build
        tgt = 1;
        rd(2'd2, 32'h01CC_CCCC, "R1 narrow inc default");
        wr(2'd2, 32'h0300_0010, 1'b0);
        ticks(5);
        rd(2'd0, 32'h10, "R7 period 3 five ticks");
        ticks(1);
        rd(2'd0, 32'h20, "R7 period 3 six ticks");
        wr(2'd2, 32'h0000_0004, 1'b0);
        ticks(2);
        rd(2'd0, 32'h28, "R7 period 0 as 1");
        wr(2'd2, 32'h0200_0001, 1'b0);
        ticks(1);
        wr(2'd2, 32'h0200_0001, 1'b0);
        ticks(1);
        rd(2'd0, 32'h28, "R7 restart no early add");
        ticks(1);
        rd(2'd0, 32'h29, "R7 add after restart");

        repeat (3) @(negedge clk);
        check(64'(sb_q.size()), 64'h0, "R10 all reads returned");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule